// File: doc/BRIEF.md
# Indirect Host Register and Memory Access Port

This block gives a host that can only issue 16-bit I/O cycles a way to reach two internal address spaces: the control-register bus and the processor-memory DMA path. Each space has its own pair of host registers. The host first writes an address register, which holds the target word address and the transfer direction. For memory, the same register also holds a 16/24-bit width select. The data then moves through a separate data register. One host transfer turns into one internal request. That request is held on a request/acknowledge port until the internal side acknowledges it.

A read starts as soon as the address register is written with the read direction. A busy flag is set until the fetched word has landed in the data register. When the host then reads the data register, the transfer is complete: the address advances and the next word is fetched. A write request goes out when the host writes the data register, and the address advances when that write is acknowledged. Memory words are 24 bits wide. In 24-bit mode the host reaches the upper byte through a second data offset.

Top module: `ioa_port`

## Requirements
- R1: After reset, every host-readable register reads zero and neither internal request is asserted.
- R2: Host offsets: 0 = control address, 1 = control data, 2 = memory address, 3 = memory data bits 15:0, 4 = memory data bits 23:16 (returned in bits 7:0). An address register holds the word address in its low address-width bits, the width select in bit 13 (memory only, 1 = 24-bit), the busy flag in bit 14 (read-only) and the direction in bit 15 (1 = write). It reads back these fields, and address bits above the parameterised width are dropped.
- R3: Writing an address register with bit 15 = 0 issues an internal read at that address. Busy reads 1 from then until the acknowledge loads the data register.
- R4: With write direction, a host write to offset 1 issues a control-bus write of that value at the current address.
- R5: A request holds its address, direction, width and write data unchanged until it is acknowledged, and it drops in the cycle after the acknowledge.
- R6: In 16-bit memory mode, a host write to offset 3 issues a memory write with bits 23:16 zero. After a read, bits 23:16 of the data register are zero, so offset 4 reads 0.
- R7: In 24-bit memory write mode, a write to offset 3 only stores the low half and issues nothing. The following write to offset 4 issues the write with the full 24-bit value.
- R8: In 24-bit memory read mode, offsets 3 and 4 return the fetched bits 15:0 and 23:16. Only the read of offset 4 completes the transfer.
- R9: The address advances by one, wrapping at the address width, when a write is acknowledged. It also advances when the host reads the final data offset in read direction (1 for control; 3 in 16-bit mode; 4 in 24-bit mode). That read then fetches the next word.
- R10: While a channel is busy, host writes to its registers and completing reads have no effect.
- R11: Writes to a data register in read direction are ignored. Host reads of data registers in write direction change nothing.
- R12: The control and memory channels run independently and may have requests outstanding at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_we_i | input | 1 | Host register write strobe |
| host_re_i | input | 1 | Host register read strobe |
| host_addr_i | input | 3 | Host register offset |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data for host_addr_i |
| ctl_req_o | output | 1 | Control-bus request |
| ctl_we_o | output | 1 | Control-bus request is a write |
| ctl_addr_o | output | CTL_AW | Control-bus word address |
| ctl_wdata_o | output | 16 | Control-bus write data |
| ctl_ack_i | input | 1 | Control-bus acknowledge |
| ctl_rdata_i | input | 16 | Control-bus read data, valid with acknowledge |
| mem_req_o | output | 1 | Memory DMA request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_wide_o | output | 1 | Memory request is 24-bit |
| mem_addr_o | output | MEM_AW | Memory word address |
| mem_wdata_o | output | 24 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 24 | Memory read data, valid with acknowledge |

## Verification
The bench builds the block with a 4-bit control address and a 3-bit memory address. This lets a few transfers carry each address register past its top word, so the wrap of R9 is checked in both channels. It also makes the dropping of high address bits in R2 visible. The acknowledge latency is varied between one and six cycles, which keeps channels busy long enough to check ignored writes and overlapping requests on both channels.

// File: rtl/ioa_pkg.sv
package ioa_pkg;
  localparam int HOST_W   = 16;
  localparam int DIR_BIT  = 15;
  localparam int BUSY_BIT = 14;
  localparam int WIDE_BIT = 13;

  typedef enum logic [2:0] {
    OFF_CTL_ADDR = 3'd0,
    OFF_CTL_DATA = 3'd1,
    OFF_MEM_ADDR = 3'd2,
    OFF_MEM_LO   = 3'd3,
    OFF_MEM_HI   = 3'd4
  } host_off_e;
endpackage

// File: rtl/ioa_host_dec.sv
module ioa_host_dec
  import ioa_pkg::*;
(
  input  logic [2:0]        host_addr_i,
  input  logic              host_we_i,
  input  logic              host_re_i,
  input  logic [HOST_W-1:0] ctl_areg_i,
  input  logic [HOST_W-1:0] ctl_lo_i,
  input  logic [HOST_W-1:0] mem_areg_i,
  input  logic [HOST_W-1:0] mem_lo_i,
  input  logic [HOST_W-1:0] mem_hi_i,
  output logic              ctl_addr_we_o,
  output logic              ctl_lo_we_o,
  output logic              ctl_lo_re_o,
  output logic              mem_addr_we_o,
  output logic              mem_lo_we_o,
  output logic              mem_lo_re_o,
  output logic              mem_hi_we_o,
  output logic              mem_hi_re_o,
  output logic [HOST_W-1:0] host_rdata_o
);
  always_comb begin
    ctl_addr_we_o = host_we_i && (host_addr_i == OFF_CTL_ADDR);
    ctl_lo_we_o   = host_we_i && (host_addr_i == OFF_CTL_DATA);
    ctl_lo_re_o   = host_re_i && (host_addr_i == OFF_CTL_DATA);
    mem_addr_we_o = host_we_i && (host_addr_i == OFF_MEM_ADDR);
    mem_lo_we_o   = host_we_i && (host_addr_i == OFF_MEM_LO);
    mem_lo_re_o   = host_re_i && (host_addr_i == OFF_MEM_LO);
    mem_hi_we_o   = host_we_i && (host_addr_i == OFF_MEM_HI);
    mem_hi_re_o   = host_re_i && (host_addr_i == OFF_MEM_HI);
  end

  always_comb begin
    case (host_addr_i)
      OFF_CTL_ADDR: host_rdata_o = ctl_areg_i;
      OFF_CTL_DATA: host_rdata_o = ctl_lo_i;
      OFF_MEM_ADDR: host_rdata_o = mem_areg_i;
      OFF_MEM_LO:   host_rdata_o = mem_lo_i;
      OFF_MEM_HI:   host_rdata_o = mem_hi_i;
      default:      host_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ioa_chan.sv
module ioa_chan
  import ioa_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_we_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic              lo_re_i,
  input  logic              hi_re_i,
  input  logic [HOST_W-1:0] wdata_i,
  output logic [HOST_W-1:0] areg_o,
  output logic [HOST_W-1:0] lo_o,
  output logic [HOST_W-1:0] hi_o,
  output logic              req_o,
  output logic              we_o,
  output logic              wide_o,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     wdata_o,
  input  logic              ack_i,
  input  logic [DW-1:0]     rdata_i
);
  localparam bit WIDE_EN = (DW > HOST_W);
  localparam int EW      = WIDE_EN ? DW - HOST_W : 1;

  logic [AW-1:0]     addr_q;
  logic              wr_q;
  logic              busy_q;
  logic              wide_q;
  logic [HOST_W-1:0] lo_q;

  logic host_ok, do_addr, start_rd, lo_wr, hi_wr, fire_wr, done_rd, ack;

  always_comb begin
    host_ok  = !busy_q;
    do_addr  = addr_we_i && host_ok;
    start_rd = do_addr && !wdata_i[DIR_BIT];
    lo_wr    = lo_we_i && host_ok && wr_q;
    hi_wr    = hi_we_i && host_ok && wr_q && wide_q;
    // narrow mode fires on the low half, wide mode waits for the upper byte
    fire_wr  = (lo_wr && !wide_q) || hi_wr;
    done_rd  = host_ok && !wr_q && (wide_q ? hi_re_i : lo_re_i);
    ack      = busy_q && ack_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
      busy_q <= 1'b0;
      lo_q   <= '0;
    end else begin
      if (do_addr) begin
        addr_q <= wdata_i[AW-1:0];
        wr_q   <= wdata_i[DIR_BIT];
      end else if (done_rd || (ack && wr_q)) begin
        addr_q <= addr_q + AW'(1);
      end

      if (ack) busy_q <= 1'b0;
      else if (start_rd || fire_wr || done_rd) busy_q <= 1'b1;

      if (lo_wr) lo_q <= wdata_i;
      else if (ack && !wr_q) lo_q <= rdata_i[HOST_W-1:0];
    end
  end

  generate
    if (WIDE_EN) begin : g_wide
      logic          mode_q;
      logic [EW-1:0] hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          mode_q <= 1'b0;
          hi_q   <= '0;
        end else begin
          if (do_addr) mode_q <= wdata_i[WIDE_BIT];
          if (hi_wr) hi_q <= wdata_i[EW-1:0];
          else if (lo_wr && !wide_q) hi_q <= '0;
          else if (ack && !wr_q) hi_q <= wide_q ? rdata_i[DW-1:HOST_W] : '0;
        end
      end
      assign wide_q  = mode_q;
      assign hi_o    = HOST_W'(hi_q);
      assign wdata_o = {hi_q, lo_q};
    end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = hi_we_i ^ hi_re_i;
      assign wide_q    = 1'b0;
      assign hi_o      = '0;
      assign wdata_o   = lo_q;
    end
  endgenerate

  logic unused_wd;
  assign unused_wd = ^wdata_i;

  always_comb begin
    areg_o           = '0;
    areg_o[AW-1:0]   = addr_q;
    areg_o[WIDE_BIT] = wide_q;
    areg_o[BUSY_BIT] = busy_q;
    areg_o[DIR_BIT]  = wr_q;
  end

  assign lo_o   = lo_q;
  assign req_o  = busy_q;
  assign we_o   = wr_q;
  assign wide_o = wide_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/ioa_port.sv
module ioa_port
  import ioa_pkg::*;
#(
  parameter int CTL_AW = 12,
  parameter int MEM_AW = 12,
  parameter int MEM_DW = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic              host_re_i,
  input  logic [2:0]        host_addr_i,
  input  logic [15:0]       host_wdata_i,
  output logic [15:0]       host_rdata_o,
  output logic              ctl_req_o,
  output logic              ctl_we_o,
  output logic [CTL_AW-1:0] ctl_addr_o,
  output logic [15:0]       ctl_wdata_o,
  input  logic              ctl_ack_i,
  input  logic [15:0]       ctl_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_wide_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [MEM_DW-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [MEM_DW-1:0] mem_rdata_i
);
  logic [HOST_W-1:0] ctl_areg, ctl_lo, ctl_hi_unused;
  logic [HOST_W-1:0] mem_areg, mem_lo, mem_hi;
  logic ctl_addr_we, ctl_lo_we, ctl_lo_re;
  logic mem_addr_we, mem_lo_we, mem_lo_re, mem_hi_we, mem_hi_re;
  logic ctl_wide_unused;

  ioa_host_dec i_dec (
    .host_addr_i   (host_addr_i),
    .host_we_i     (host_we_i),
    .host_re_i     (host_re_i),
    .ctl_areg_i    (ctl_areg),
    .ctl_lo_i      (ctl_lo),
    .mem_areg_i    (mem_areg),
    .mem_lo_i      (mem_lo),
    .mem_hi_i      (mem_hi),
    .ctl_addr_we_o (ctl_addr_we),
    .ctl_lo_we_o   (ctl_lo_we),
    .ctl_lo_re_o   (ctl_lo_re),
    .mem_addr_we_o (mem_addr_we),
    .mem_lo_we_o   (mem_lo_we),
    .mem_lo_re_o   (mem_lo_re),
    .mem_hi_we_o   (mem_hi_we),
    .mem_hi_re_o   (mem_hi_re),
    .host_rdata_o  (host_rdata_o)
  );

  ioa_chan #(.AW(CTL_AW), .DW(HOST_W)) i_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_we_i (ctl_addr_we),
    .lo_we_i   (ctl_lo_we),
    .hi_we_i   (1'b0),
    .lo_re_i   (ctl_lo_re),
    .hi_re_i   (1'b0),
    .wdata_i   (host_wdata_i),
    .areg_o    (ctl_areg),
    .lo_o      (ctl_lo),
    .hi_o      (ctl_hi_unused),
    .req_o     (ctl_req_o),
    .we_o      (ctl_we_o),
    .wide_o    (ctl_wide_unused),
    .addr_o    (ctl_addr_o),
    .wdata_o   (ctl_wdata_o),
    .ack_i     (ctl_ack_i),
    .rdata_i   (ctl_rdata_i)
  );

  ioa_chan #(.AW(MEM_AW), .DW(MEM_DW)) i_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_we_i (mem_addr_we),
    .lo_we_i   (mem_lo_we),
    .hi_we_i   (mem_hi_we),
    .lo_re_i   (mem_lo_re),
    .hi_re_i   (mem_hi_re),
    .wdata_i   (host_wdata_i),
    .areg_o    (mem_areg),
    .lo_o      (mem_lo),
    .hi_o      (mem_hi),
    .req_o     (mem_req_o),
    .we_o      (mem_we_o),
    .wide_o    (mem_wide_o),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_wdata_o),
    .ack_i     (mem_ack_i),
    .rdata_i   (mem_rdata_i)
  );
endmodule

// File: rtl/ioa_port_chk.sv
module ioa_port_chk #(
  parameter int CTL_AW = 12,
  parameter int MEM_AW = 12,
  parameter int MEM_DW = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_we_i,
  input logic              host_re_i,
  input logic              ctl_req_o,
  input logic              ctl_we_o,
  input logic [CTL_AW-1:0] ctl_addr_o,
  input logic [15:0]       ctl_wdata_o,
  input logic              ctl_ack_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_wide_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic [MEM_DW-1:0] mem_wdata_o,
  input logic              mem_ack_i
);
  assert_ctl_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_req_o && !ctl_ack_i |=> ctl_req_o && $stable(ctl_addr_o) && $stable(ctl_we_o)
                                && $stable(ctl_wdata_o));

  assert_ctl_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_req_o && ctl_ack_i |=> !ctl_req_o);

  assert_mem_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wide_o) && $stable(mem_wdata_o));

  assert_mem_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> !mem_req_o);

  assert_narrow_upper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && !mem_wide_o |-> mem_wdata_o[MEM_DW-1:16] == '0);

  assert_ctl_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_req_o) |-> $past(host_we_i || host_re_i));

  assert_mem_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(host_we_i || host_re_i));
endmodule

bind ioa_port ioa_port_chk #(.CTL_AW(CTL_AW), .MEM_AW(MEM_AW), .MEM_DW(MEM_DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_we_i   (host_we_i),
  .host_re_i   (host_re_i),
  .ctl_req_o   (ctl_req_o),
  .ctl_we_o    (ctl_we_o),
  .ctl_addr_o  (ctl_addr_o),
  .ctl_wdata_o (ctl_wdata_o),
  .ctl_ack_i   (ctl_ack_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_wide_o  (mem_wide_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/test_ioa_port.sv
module test_ioa_port;
  localparam int CTL_AW = 4;
  localparam int MEM_AW = 3;
  localparam int MEM_DW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              h_we = 1'b0, h_re = 1'b0;
  logic [2:0]        h_addr = '0;
  logic [15:0]       h_wd = '0;
  logic [15:0]       h_rd;
  logic              ctl_req, ctl_we, ctl_ack = 1'b0;
  logic [CTL_AW-1:0] ctl_addr;
  logic [15:0]       ctl_wdata, ctl_rdata = '0;
  logic              mem_req, mem_we, mem_wide, mem_ack = 1'b0;
  logic [MEM_AW-1:0] mem_addr;
  logic [MEM_DW-1:0] mem_wdata, mem_rdata = '0;

  ioa_port #(.CTL_AW(CTL_AW), .MEM_AW(MEM_AW), .MEM_DW(MEM_DW)) i_ioa_port (
    .clk_i(clk), .rst_ni(rst_n),
    .host_we_i(h_we), .host_re_i(h_re), .host_addr_i(h_addr),
    .host_wdata_i(h_wd), .host_rdata_o(h_rd),
    .ctl_req_o(ctl_req), .ctl_we_o(ctl_we), .ctl_addr_o(ctl_addr),
    .ctl_wdata_o(ctl_wdata), .ctl_ack_i(ctl_ack), .ctl_rdata_i(ctl_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_wide_o(mem_wide),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata)
  );

  int n_cmp = 0, n_bad = 0;
  string phase = "R1";

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // responder: acknowledges after lat idle negedges, stores writes
  int lat = 1;
  int ctl_cnt = 0, mem_cnt = 0;
  logic [15:0] ctl_store [int];
  logic [23:0] mem_store [int];

  always @(negedge clk) begin
    if (ctl_ack) begin
      ctl_ack = 1'b0; ctl_cnt = 0;
    end else if (ctl_req) begin
      if (ctl_cnt >= lat) begin
        ctl_ack = 1'b1;
        if (ctl_we) ctl_store[int'(ctl_addr)] = ctl_wdata;
        ctl_rdata = ctl_store.exists(int'(ctl_addr)) ? ctl_store[int'(ctl_addr)]
                                                    : 16'h3C00 + 16'(ctl_addr);
      end else ctl_cnt++;
    end
    if (mem_ack) begin
      mem_ack = 1'b0; mem_cnt = 0;
    end else if (mem_req) begin
      if (mem_cnt >= lat) begin
        mem_ack = 1'b1;
        if (mem_we) mem_store[int'(mem_addr)] = mem_wdata;
        mem_rdata = mem_store.exists(int'(mem_addr)) ? mem_store[int'(mem_addr)]
                                                    : 24'h5A1000 + 24'(mem_addr);
      end else mem_cnt++;
    end
  end

  // reference model: index 0 = control channel, 1 = memory channel
  int m_addr[2], m_wr[2], m_wide[2], m_busy[2], m_data[2];

  function automatic int exp_rd(input int off);
    case (off)
      0: return (m_wr[0] << 15) | (m_busy[0] << 14) | m_addr[0];
      1: return m_data[0] & 'hFFFF;
      2: return (m_wr[1] << 15) | (m_busy[1] << 14) | (m_wide[1] << 13) | m_addr[1];
      3: return m_data[1] & 'hFFFF;
      4: return (m_data[1] >> 16) & 'hFF;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int ack_in[2];
    int rd_in[2];
    ack_in[0] = int'(ctl_ack); ack_in[1] = int'(mem_ack);
    rd_in[0]  = int'(ctl_rdata); rd_in[1] = int'(mem_rdata);
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_addr[c] = 0; m_wr[c] = 0; m_wide[c] = 0; m_busy[c] = 0; m_data[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int mask, a_off, lo_off, wd, fin_off;
        mask   = (1 << (c == 1 ? MEM_AW : CTL_AW)) - 1;
        a_off  = c == 1 ? 2 : 0;
        lo_off = c == 1 ? 3 : 1;
        wd     = int'(h_wd);
        fin_off = m_wide[c] != 0 ? 4 : lo_off;
        if (m_busy[c] != 0 && ack_in[c] != 0) begin
          m_busy[c] = 0;
          if (m_wr[c] != 0) m_addr[c] = (m_addr[c] + 1) & mask;
          else m_data[c] = m_wide[c] != 0 ? rd_in[c] : (rd_in[c] & 'hFFFF);
        end else if (m_busy[c] == 0) begin
          if (h_we && int'(h_addr) == a_off) begin
            m_addr[c] = wd & mask;
            m_wr[c]   = (wd >> 15) & 1;
            m_wide[c] = c == 1 ? (wd >> 13) & 1 : 0;
            if (m_wr[c] == 0) m_busy[c] = 1;
          end else if (h_we && int'(h_addr) == lo_off && m_wr[c] != 0) begin
            if (m_wide[c] != 0) m_data[c] = (m_data[c] & 'hFF0000) | wd;
            else begin m_data[c] = wd; m_busy[c] = 1; end
          end else if (c == 1 && h_we && h_addr == 3'd4 && m_wr[c] != 0 && m_wide[c] != 0) begin
            m_data[c] = (m_data[c] & 'hFFFF) | ((wd & 'hFF) << 16);
            m_busy[c] = 1;
          end else if (h_re && int'(h_addr) == fin_off && m_wr[c] == 0) begin
            m_addr[c] = (m_addr[c] + 1) & mask;
            m_busy[c] = 1;
          end
        end
      end
    end
    #2;
    chk(phase, "ctl_req", int'(ctl_req), m_busy[0]);
    if (m_busy[0] != 0) begin
      chk(phase, "ctl_we", int'(ctl_we), m_wr[0]);
      chk(phase, "ctl_addr", int'(ctl_addr), m_addr[0]);
      if (m_wr[0] != 0) chk(phase, "ctl_wdata", int'(ctl_wdata), m_data[0]);
    end
    chk(phase, "mem_req", int'(mem_req), m_busy[1]);
    if (m_busy[1] != 0) begin
      chk(phase, "mem_we", int'(mem_we), m_wr[1]);
      chk(phase, "mem_wide", int'(mem_wide), m_wide[1]);
      chk(phase, "mem_addr", int'(mem_addr), m_addr[1]);
      if (m_wr[1] != 0) chk(phase, "mem_wdata", int'(mem_wdata), m_data[1]);
    end
    chk(phase, "host_rdata", int'(h_rd), exp_rd(int'(h_addr)));
  end

  task automatic hwr(input int off, input int val);
    @(negedge clk);
    h_we = 1'b1; h_addr = 3'(off); h_wd = 16'(val);
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic hrd(input int off, output int val);
    @(negedge clk);
    h_re = 1'b1; h_addr = 3'(off);
    #1 val = int'(h_rd);
    @(negedge clk);
    h_re = 1'b0;
  endtask

  task automatic expect_rd(input string tag, input int off, input int exp);
    int v;
    hrd(off, v);
    chk(tag, $sformatf("offset %0d", off), v, exp);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy[0] != 0 || m_busy[1] != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R1";
    expect_rd("R1", 0, 0);
    expect_rd("R1", 2, 0);
    expect_rd("R1", 4, 0);

    phase = "R2";
    hwr(2, 'hA003);
    expect_rd("R2", 2, 'hA003);
    hwr(0, 'h80F5);
    expect_rd("R2", 0, 'h8005);

    phase = "R4";
    hwr(1, 'h1111);
    wait_idle();
    expect_rd("R4", 0, 'h8006);
    expect_rd("R4", 1, 'h1111);

    phase = "R9";
    hwr(0, 'h800F);
    hwr(1, 'h2222);
    wait_idle();
    expect_rd("R9", 0, 'h8000);

    phase = "R3";
    hwr(0, 'h0005);
    wait_idle();
    expect_rd("R3", 1, 'h1111);
    wait_idle();
    expect_rd("R3", 0, 'h0006);
    expect_rd("R3", 1, 'h3C06);
    wait_idle();
    lat = 3;
    hwr(0, 'h0007);
    expect_rd("R3", 0, 'h4007);
    wait_idle();

    phase = "R10";
    lat = 6;
    hwr(2, 'h0001);
    hwr(2, 'h8004);
    hwr(3, 'hFFFF);
    wait_idle();
    lat = 1;
    expect_rd("R10", 2, 'h0001);
    expect_rd("R10", 3, 'h1001);
    expect_rd("R6", 4, 0);
    wait_idle();

    phase = "R6";
    hwr(2, 'h8002);
    hwr(3, 'h1234);
    wait_idle();
    expect_rd("R6", 2, 'h8003);
    hwr(2, 'h0002);
    wait_idle();
    expect_rd("R6", 3, 'h1234);
    expect_rd("R6", 4, 0);
    wait_idle();

    phase = "R7";
    hwr(2, 'hA004);
    hwr(3, 'hBEEF);
    chk("R7", "mem_req after low half", int'(mem_req), 0);
    expect_rd("R7", 2, 'hA004);
    hwr(4, 'h00CD);
    wait_idle();
    expect_rd("R7", 2, 'hA005);

    phase = "R8";
    hwr(2, 'h2004);
    wait_idle();
    expect_rd("R8", 3, 'hBEEF);
    expect_rd("R8", 2, 'h2004);
    expect_rd("R8", 4, 'h00CD);
    wait_idle();
    expect_rd("R8", 2, 'h2005);
    expect_rd("R8", 4, 'h005A);
    wait_idle();
    expect_rd("R8", 4, 'h005A);
    wait_idle();
    expect_rd("R8", 4, 'h005A);
    wait_idle();
    expect_rd("R9", 2, 'h2000);

    phase = "R11";
    hwr(0, 'h0003);
    wait_idle();
    hwr(1, 'h9999);
    expect_rd("R11", 1, 'h3C03);
    wait_idle();
    hwr(0, 'h8002);
    expect_rd("R11", 1, 'h3C04);
    expect_rd("R11", 0, 'h8002);

    phase = "R12";
    lat = 4;
    hwr(0, 'h0008);
    hwr(2, 'h8001);
    hwr(3, 'h0042);
    chk("R12", "both requests", int'(ctl_req) + int'(mem_req), 2);
    wait_idle();
    expect_rd("R12", 2, 'h8002);
    expect_rd("R12", 1, 'h3C08);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule